// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. It tracks the sixteen-state TAP sequence from the mode-select pin, holds an instruction shift stage with its own parallel latch, provides a one-bit bypass path, and decodes the latched instruction into the controls that an external boundary register needs. Those controls are a select, a drive mode, a global output disable, and capture, shift and update strobes. The boundary register itself lives outside. Its serial output comes back into this block and is routed to the test data output whenever that register is the selected path.

Five operations are decoded. External test and sample/preload select the boundary register. Clamp keeps the pins driven from the boundary update stage while the bypass bit is the scan path. High-impedance turns off every output driver and also uses the bypass bit. Every other code behaves as bypass. The test data output is launched on the falling test clock edge, and its enable is high only while a shift state is active. All control outputs come from flops that load the value for the state being entered, so each one changes on the same rising edge as the TAP state.

Top module: `tap_ctrl`

## Requirements
- R1: The controller follows the standard TAP transitions on `tms` at each rising `tck` edge. This includes the pause loops. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state.
- R2: Driving `trst_n` low forces Test-Logic-Reset and the bypass instruction at once, with no clock edge needed.
- R3: In Capture-IR the instruction shift stage loads binary 0001, and it shifts that pattern out on `tdo`, least significant bit first, as the sequence 1,0,0,0.
- R4: The instruction is shifted in from `tdi` least significant bit first. The decoded controls change only when Update-IR is left; during the IR shift and in Exit1-IR they keep the previous instruction.
- R5: Entering Test-Logic-Reset sets the instruction latch to all ones, which decodes as bypass: `bsr_select`, `bsr_mode` and `out_disable` are all 0.
- R6: Code 0000 (external test) gives `bsr_select`=1, `bsr_mode`=1 and `out_disable`=0.
- R7: Code 0001 (sample/preload) gives `bsr_select`=1, `bsr_mode`=0 and `out_disable`=0.
- R8: Code 0100 (high-impedance) gives `out_disable`=1 with `bsr_select`=0 and `bsr_mode`=0, and the scan path is the bypass bit.
- R9: Code 0101 (clamp) gives `bsr_mode`=1 with `bsr_select`=0 and `out_disable`=0, and the scan path is the bypass bit.
- R10: Every code with bit 3 set, and codes 0010 and 0011, decode as bypass, with all three mode controls at 0.
- R11: On the bypass path the bit captures 0 in Capture-DR. In Shift-DR, `tdo` then presents `tdi` delayed by one shift.
- R12: `bsr_capture`, `bsr_shift` and `bsr_update` are high exactly during Capture-DR, Shift-DR and Update-DR respectively, and only while the boundary register is selected. While it is selected, `tdo` in Shift-DR carries `bsr_tdo`, which is the output of the boundary register's bit 0 cell.
- R13: `tdo` changes only on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-IR and Shift-DR and holds its value through the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Test data out, launched on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_select | output | 1 | Boundary register is the selected data register |
| bsr_mode | output | 1 | Pins driven from the boundary update stage |
| out_disable | output | 1 | Global disable of all output drivers |
| bsr_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bsr_update | output | 1 | Boundary update strobe (Update-DR) |

## Verification
The hardest situation to reach is an instruction change that happens in the middle of a sequence while other controls are still active. One case is an external-test instruction that a five-cycle `tms` escape from Shift-DR has to abandon. Another is an asynchronous reset that lands between clock edges while the boundary register is selected. The stimulus first loads external test, walks into the DR column, and then applies either the `tms` escape or `trst_n`. It checks that the controls still hold after four escape cycles and fall on the fifth, and that they fall at once on reset. A pause-and-resume scan covers a further case: a bit shifted on the exit edge must reappear when shifting resumes through Exit2-DR.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR,    S_RTI,
    S_SEL_DR, S_CAP_DR, S_SHF_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SHF_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    I_BYPASS, I_EXTEST, I_SAMPLE, I_CLAMP, I_HIGHZ
  } instr_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_d
);

  always_comb begin
    case (state_q)
      S_TLR:    state_d = tms ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
      S_SHF_DR: state_d = tms ? S_EX1_DR : S_SHF_DR;
      S_EX1_DR: state_d = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms ? S_UPD_DR : S_SHF_DR;
      S_UPD_DR: state_d = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
      S_SHF_IR: state_d = tms ? S_EX1_IR : S_SHF_IR;
      S_EX1_IR: state_d = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms ? S_UPD_IR : S_SHF_IR;
      S_UPD_IR: state_d = tms ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= S_TLR;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int unsigned       IR_W        = 4,
  parameter logic [IR_W-1:0]   CAPTURE_PAT = IR_W'(1)
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state_q,
  input  tap_state_e      state_d,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_next,
  output logic            ir_lsb
);

  localparam logic [IR_W-1:0] RESET_CODE = {IR_W{1'b1}};

  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] lat_q;

  // shift stage: fixed capture, LSB leaves first, TDI enters at the top
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= CAPTURE_PAT;
    end else begin
      case (state_q)
        S_CAP_IR: sr_q <= CAPTURE_PAT;
        S_SHF_IR: sr_q <= {tdi, sr_q[IR_W-1:1]};
        default:  sr_q <= sr_q;
      endcase
    end
  end

  // parallel latch: forced to all ones on entry to reset state
  always_comb begin
    if (state_d == S_TLR)        ir_next = RESET_CODE;
    else if (state_q == S_UPD_IR) ir_next = sr_q;
    else                          ir_next = lat_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) lat_q <= RESET_CODE;
    else        lat_q <= ir_next;
  end

  assign ir_lsb = sr_q[0];

endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W        = 4,
  parameter logic [IR_W-1:0] CODE_EXTEST = IR_W'(0),
  parameter logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1),
  parameter logic [IR_W-1:0] CODE_HIGHZ  = IR_W'(4),
  parameter logic [IR_W-1:0] CODE_CLAMP  = IR_W'(5)
) (
  input  logic [IR_W-1:0] code,
  output instr_e          instr
);

  always_comb begin
    if (code == CODE_EXTEST)      instr = I_EXTEST;
    else if (code == CODE_SAMPLE) instr = I_SAMPLE;
    else if (code == CODE_HIGHZ)  instr = I_HIGHZ;
    else if (code == CODE_CLAMP)  instr = I_CLAMP;
    else                          instr = I_BYPASS;
  end

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
#(
  parameter int unsigned     IR_W        = 4,
  parameter bit              HAS_TRST    = 1'b1,
  parameter logic [IR_W-1:0] CODE_EXTEST = IR_W'(0),
  parameter logic [IR_W-1:0] CODE_SAMPLE = IR_W'(1),
  parameter logic [IR_W-1:0] CODE_HIGHZ  = IR_W'(4),
  parameter logic [IR_W-1:0] CODE_CLAMP  = IR_W'(5)
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_select,
  output logic bsr_mode,
  output logic out_disable,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update
);

  localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

  logic            rst_n;
  tap_state_e      state_q;
  tap_state_e      state_d;
  logic [IR_W-1:0] ir_next;
  logic            ir_lsb;
  instr_e          instr_d;
  logic            sel_d, mode_d, dis_d;
  logic            byp_q;

  generate
    if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
    end else begin : g_no_trst
      assign rst_n = 1'b1;
    end
  endgenerate

  tap_fsm u_fsm (
    .tck     (tck),
    .rst_n   (rst_n),
    .tms     (tms),
    .state_q (state_q),
    .state_d (state_d)
  );

  tap_ir #(
    .IR_W        (IR_W),
    .CAPTURE_PAT (CAPTURE_PAT)
  ) u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state_q (state_q),
    .state_d (state_d),
    .tdi     (tdi),
    .ir_next (ir_next),
    .ir_lsb  (ir_lsb)
  );

  tap_decode #(
    .IR_W        (IR_W),
    .CODE_EXTEST (CODE_EXTEST),
    .CODE_SAMPLE (CODE_SAMPLE),
    .CODE_HIGHZ  (CODE_HIGHZ),
    .CODE_CLAMP  (CODE_CLAMP)
  ) u_dec (
    .code  (ir_next),
    .instr (instr_d)
  );

  assign sel_d  = (instr_d == I_EXTEST) || (instr_d == I_SAMPLE);
  assign mode_d = (instr_d == I_EXTEST) || (instr_d == I_CLAMP);
  assign dis_d  = (instr_d == I_HIGHZ);

  // controls registered from the state being entered
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      bsr_select  <= 1'b0;
      bsr_mode    <= 1'b0;
      out_disable <= 1'b0;
      bsr_capture <= 1'b0;
      bsr_shift   <= 1'b0;
      bsr_update  <= 1'b0;
    end else begin
      bsr_select  <= sel_d;
      bsr_mode    <= mode_d;
      out_disable <= dis_d;
      bsr_capture <= sel_d && (state_d == S_CAP_DR);
      bsr_shift   <= sel_d && (state_d == S_SHF_DR);
      bsr_update  <= sel_d && (state_d == S_UPD_DR);
    end
  end

  // one-bit bypass path
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else begin
      case (state_q)
        S_CAP_DR: byp_q <= 1'b0;
        S_SHF_DR: byp_q <= tdi;
        default:  byp_q <= byp_q;
      endcase
    end
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      case (state_q)
        S_SHF_IR: begin
          tdo    <= ir_lsb;
          tdo_oe <= 1'b1;
        end
        S_SHF_DR: begin
          tdo    <= bsr_select ? bsr_tdo : byp_q;
          tdo_oe <= 1'b1;
        end
        default: begin
          tdo    <= tdo;
          tdo_oe <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
  import tap_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input tap_state_e state_q,
  input tap_state_e state_d,
  input logic       bsr_select,
  input logic       bsr_mode,
  input logic       out_disable,
  input logic       bsr_capture,
  input logic       bsr_shift,
  input logic       bsr_update
);

  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update})); // R12

  AST_STROBE_NEEDS_SEL: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> bsr_select); // R12

  AST_SHIFT_IN_STATE: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_shift |-> (state_q == S_SHF_DR)); // R12

  AST_RESET_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == S_TLR) |-> (!bsr_select && !bsr_mode && !out_disable)); // R5

  AST_INSTR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q != S_UPD_IR && state_d != S_TLR)
      |=> $stable({bsr_select, bsr_mode, out_disable})); // R4

  AST_HIGHZ_ALONE: assert property (@(posedge tck) disable iff (!trst_n)
    out_disable |-> (!bsr_mode && !bsr_select)); // R8

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .state_q     (state_q),
  .state_d     (state_d),
  .bsr_select  (bsr_select),
  .bsr_mode    (bsr_mode),
  .out_disable (out_disable),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update)
);

// File: tb/tb_tap_ctrl.sv
`timescale 1ns/1ps
module tb_tap_ctrl;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsr_tdo = 1'b0;
  logic tdo, tdo_oe, bsr_select, bsr_mode, out_disable;
  logic bsr_capture, bsr_shift, bsr_update;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] prev_ctl = 3'b000; // {select, mode, disable}

  // {code, select, mode, disable}
  localparam logic [6:0] VEC [16] = '{
    {4'h0, 3'b110}, {4'h1, 3'b100}, {4'h2, 3'b000}, {4'h3, 3'b000},
    {4'h4, 3'b001}, {4'h5, 3'b010}, {4'h6, 3'b000}, {4'h7, 3'b000},
    {4'h8, 3'b000}, {4'h9, 3'b000}, {4'hA, 3'b000}, {4'hB, 3'b000},
    {4'hC, 3'b000}, {4'hD, 3'b000}, {4'hE, 3'b000}, {4'hF, 3'b000}
  };

  tap_ctrl dut (
    .tck (tck), .trst_n (trst_n), .tms (tms), .tdi (tdi), .bsr_tdo (bsr_tdo),
    .tdo (tdo), .tdo_oe (tdo_oe), .bsr_select (bsr_select), .bsr_mode (bsr_mode),
    .out_disable (out_disable), .bsr_capture (bsr_capture),
    .bsr_shift (bsr_shift), .bsr_update (bsr_update)
  );

  always #5 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] code);
    case (code)
      4'h0: return "R6";
      4'h1: return "R7";
      4'h4: return "R8";
      4'h5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(negedge tck);
    #2;
  endtask

  // from Run-Test/Idle, load a code, back in Run-Test/Idle
  task automatic load_ir(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check("R13 oe in Shift-IR", tdo_oe, 1);
    for (int i = 0; i < 4; i++) begin
      check("R3 capture pattern bit", tdo, (i == 0) ? 1 : 0);
      step(i == 3, code[i]);
    end
    check("R13 oe in Exit1-IR", tdo_oe, 0);
    check("R4 controls held before update", {bsr_select, bsr_mode, out_disable}, prev_ctl);
    step(1, 0);
    check("R4 controls held in Update-IR", {bsr_select, bsr_mode, out_disable}, prev_ctl);
    step(0, 0);
  endtask

  // three-bit DR scan from Run-Test/Idle back to Run-Test/Idle
  task automatic scan_dr(input logic sel);
    logic [2:0] tpat;
    logic [2:0] bpat;
    string r;
    tpat = 3'b101;
    bpat = 3'b001;
    r = sel ? "R12" : "R11";
    step(1, 0); step(0, 0);
    check("R12 capture strobe", bsr_capture, sel);
    bsr_tdo = bpat[0];
    step(0, 0);
    check("R12 shift strobe", bsr_shift, sel);
    check("R13 oe in Shift-DR", tdo_oe, 1);
    for (int i = 0; i < 3; i++) begin
      if (sel) check(r, tdo, bpat[i]);
      else     check(r, tdo, (i == 0) ? 1'b0 : tpat[i-1]);
      if (i < 2) bsr_tdo = bpat[i+1];
      step(i == 2, tpat[i]);
    end
    check("R13 oe in Exit1-DR", tdo_oe, 0);
    check("R12 shift strobe off", bsr_shift, 0);
    step(1, 0);
    check("R12 update strobe", bsr_update, sel);
    step(0, 0);
    check("R12 strobes idle", {bsr_capture, bsr_shift, bsr_update}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset state
    repeat (3) @(negedge tck);
    #2;
    check("R2 controls in reset", {bsr_select, bsr_mode, out_disable}, 0);
    check("R2 oe in reset", tdo_oe, 0);
    trst_n = 1'b1;
    step(1, 0);
    check("R5 bypass after reset", {bsr_select, bsr_mode, out_disable}, 0);
    check("R12 strobes after reset", {bsr_capture, bsr_shift, bsr_update}, 0);
    step(0, 0);

    // table walk over all codes
    for (int v = 0; v < 16; v++) begin
      load_ir(VEC[v][6:3]);
      check(tag(VEC[v][6:3]), {bsr_select, bsr_mode, out_disable}, VEC[v][2:0]);
      prev_ctl = VEC[v][2:0];
      scan_dr(VEC[v][2]);
    end

    // R1: five TMS ones from Shift-DR reach reset
    load_ir(4'h0);
    prev_ctl = 3'b110;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    check("R1 not yet in reset after four", {bsr_select, bsr_mode}, 2'b11);
    step(1, 0);
    check("R1 R5 reset after five", {bsr_select, bsr_mode, out_disable}, 0);
    prev_ctl = 3'b000;
    step(0, 0);

    // R2: asynchronous reset between edges
    load_ir(4'h0);
    prev_ctl = 3'b110;
    step(1, 0);
    trst_n = 1'b0;
    #1;
    check("R2 async clears controls", {bsr_select, bsr_mode, out_disable}, 0);
    step(1, 0);
    trst_n = 1'b1;
    prev_ctl = 3'b000;
    step(0, 0);
    scan_dr(1'b0);

    // R1 pause loop, R11 bypass, R13 edge behaviour
    step(1, 0); step(0, 0); step(0, 0);
    check("R11 bypass captured zero", tdo, 0);
    step(0, 1);
    check("R11 bypass delay", tdo, 1);
    step(1, 0);
    check("R13 oe low in Exit1-DR", tdo_oe, 0);
    step(0, 1); step(0, 1);
    check("R13 oe low in Pause-DR", tdo_oe, 0);
    step(1, 1); step(0, 1);
    check("R1 resume keeps exit-edge bit", tdo, 0);
    check("R1 oe after resume", tdo_oe, 1);
    tdi = 1'b1;
    @(posedge tck);
    #1;
    check("R13 tdo steady at rising edge", tdo, 0);
    @(negedge tck);
    #2;
    check("R13 tdo moves at falling edge", tdo, 1);
    step(1, 0); step(1, 0); step(0, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule